// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block feeds a multi-modulus feedback divider in a fractional-N synthesizer. Every time the divider completes a cycle it pulses an advance strobe, and the block answers with the integer modulus to use for the next cycle. Over many cycles the moduli average to an integer part plus a fraction. The fraction is the 18-bit fractional control word plus one half, divided by 2^18. Put another way, the modulator runs on a 19-bit word whose least significant bit is always 1, so the average is never exactly an integer.

A third-order cascade of three first-order accumulators (a 1-1-1 noise-shaping modulator) produces a signed correction between -3 and +4. The correction is added to the integer part. This pushes the quantization error of the divide ratio toward high offset frequencies, where the loop filter removes it. An integer-only control bypasses the modulator when phase noise matters more than frequency resolution. In that mode the ratio is exactly the integer part and all modulator state is held at zero. Leaving the mode restarts the sequence from its reset state.

Top module: `dsm_frac_divctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `div_o` equals `{1'b0, mint_i}`, meaning the stored correction is zero.
- R2: Outside integer-only mode, `div_o` equals `mint_i` plus a signed correction that always lies between -3 and +4 inclusive. The correction changes only through strobes.
- R3: In a cycle where `adv_i` is low, the stored correction keeps its value, so `div_o` does not move while `mint_i` is held.
- R4: While `int_mode_i` is high, `div_o` equals `mint_i` exactly. At every clock edge in that mode all accumulators and carry history are cleared.
- R5: After integer-only mode is released, the sequence of outputs seen on later strobes is identical to the sequence seen after reset with the same control words.
- R6: Starting from the cleared state, the outputs of k·2^(FRAC_W+1) consecutive strobes sum to between E-1 and E+2, where E = mint·k·2^(FRAC_W+1) + k·(2·mfrac+1).
- R7: With `mfrac_i` all ones and starting from the cleared state, the first three strobes give corrections 0, +3 and 0.
- R8: A change of `mint_i` appears on `div_o` in the same cycle, shifted by the same amount, without any strobe and without disturbing the modulator state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mint_i | input | INT_W (7) | Integer part of the divide ratio |
| mfrac_i | input | FRAC_W (18) | Fractional control word |
| int_mode_i | input | 1 | High selects integer-only division with the modulator held cleared |
| adv_i | input | 1 | One-cycle strobe, one per feedback-divider cycle |
| div_o | output | INT_W+1 (8) | Divide ratio for the current feedback-divider cycle |

## Verification
The embedded properties are checked on every cycle. They cover the -3..+4 bound on the correction, that the correction holds between strobes, that state is cleared after integer-only cycles, that the cleared stages pass the input word straight through, and the wrap direction of each accumulator on a carry. The long-run average, the exact start-up sequence for an all-ones fraction, and the replay after leaving integer-only mode are sequence properties. Only the bench scenarios can show these. The average is checked with a narrower instance so that whole modulator periods fit in a short run.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    localparam int ORDER   = 3;
    localparam int OFF_MIN = -3;
    localparam int OFF_MAX = 4;

    typedef logic signed [3:0] dsm_off_t;

    // carry history needed by the cancellation network
    typedef struct packed {
        logic c2_d;
        logic c3_d1;
        logic c3_d2;
    } dsm_hist_t;

    // y = c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3
    function automatic dsm_off_t mash3_combine(input logic [ORDER-1:0] c,
                                               input dsm_hist_t h);
        int s;
        s = int'(c[0]) + int'(c[1]) - int'(h.c2_d)
          + int'(c[2]) - 2 * int'(h.c3_d1) + int'(h.c3_d2);
        return dsm_off_t'(s);
    endfunction

endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   full;

    assign full    = {1'b0, acc_q} + {1'b0, in_word};
    assign sum_o   = full[W-1:0];
    assign carry_o = full[W];

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (adv)
            acc_q <= sum_o;
    end

    // a carry means the modulus wrapped, so the stored value fell
    p_wrap_down_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && carry_o) |=> (acc_q < $past(acc_q)));
    p_nowrap_up_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && !carry_o) |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/dsm_noise_cancel.sv
module dsm_noise_cancel
    import dsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [ORDER-1:0] carry_i,
    output dsm_off_t         off_o
);
    dsm_hist_t hist_q;
    dsm_off_t  off_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q <= '0;
            off_q  <= '0;
        end else if (adv) begin
            off_q        <= mash3_combine(carry_i, hist_q);
            hist_q.c2_d  <= carry_i[1];
            hist_q.c3_d1 <= carry_i[2];
            hist_q.c3_d2 <= hist_q.c3_d1;
        end
    end

    assign off_o = off_q;

    p_off_range_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(off_q) >= OFF_MIN) && (int'(off_q) <= OFF_MAX));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(adv) && !$past(rst) && !$past(clr)) |-> $stable(off_q));

    p_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (off_q == '0 && hist_q == '0));

endmodule

// File: rtl/dsm_frac_divctl.sv
module dsm_frac_divctl
    import dsm_pkg::*;
#(
    parameter int INT_W  = 7,
    parameter int FRAC_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  mint_i,
    input  logic [FRAC_W-1:0] mfrac_i,
    input  logic              int_mode_i,
    input  logic              adv_i,
    output logic [INT_W:0]    div_o
);
    localparam int ACC_W = FRAC_W + 1;
    localparam int SW    = INT_W + 2;

    // half-LSB offset: effective word always odd
    logic [ACC_W-1:0]            x_word;
    logic [ORDER-1:0][ACC_W-1:0] stage_in;
    logic [ORDER-1:0][ACC_W-1:0] stage_sum;
    logic [ORDER-1:0]            carry;
    dsm_off_t                    off_q;

    assign x_word = {mfrac_i, 1'b1};

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_in[g] = x_word;
        end else begin : g_tail
            assign stage_in[g] = stage_sum[g-1];
        end
        dsm_acc_stage #(.W(ACC_W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .clr     (int_mode_i),
            .adv     (adv_i),
            .in_word (stage_in[g]),
            .sum_o   (stage_sum[g]),
            .carry_o (carry[g])
        );
    end

    dsm_noise_cancel u_cancel (
        .clk     (clk),
        .rst     (rst),
        .clr     (int_mode_i),
        .adv     (adv_i),
        .carry_i (carry),
        .off_o   (off_q)
    );

    logic signed [SW-1:0] mint_w, off_w, wide;
    assign mint_w = signed'({2'b00, mint_i});
    assign off_w  = SW'(off_q);
    assign wide   = int_mode_i ? mint_w : (mint_w + off_w);
    assign div_o  = wide[INT_W:0];

    p_int_exact_r4: assert property (@(posedge clk) disable iff (rst)
        int_mode_i |-> (div_o == {1'b0, mint_i}));

    // cleared accumulators pass the input word through every stage
    p_cleared_sum_r5: assert property (@(posedge clk) disable iff (rst)
        $past(int_mode_i) |-> (stage_sum[ORDER-1] == x_word));

    p_nonneg_r2: assert property (@(posedge clk) disable iff (rst)
        (!int_mode_i && mint_i >= INT_W'(3)) |-> !wide[SW-1]);

endmodule

// File: tb/tb_dsm_frac_divctl.sv
`timescale 1ns/1ps
module tb_dsm_frac_divctl;

    localparam int SFW = 10;               // narrow instance fraction width
    localparam int SM  = 1 << (SFW + 1);   // its modulus
    localparam int SK  = 4;                // periods summed
    localparam int SN  = SK * SM;

    logic clk = 1'b0;
    logic rst;
    logic [6:0]  mint;
    logic [17:0] mfrac;
    logic        im, adv;
    logic [7:0]  div;

    logic [6:0]     mint_s;
    logic [SFW-1:0] mfrac_s;
    logic           im_s, adv_s;
    logic [7:0]     div_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dsm_frac_divctl dut (
        .clk(clk), .rst(rst), .mint_i(mint), .mfrac_i(mfrac),
        .int_mode_i(im), .adv_i(adv), .div_o(div)
    );

    dsm_frac_divctl #(.INT_W(7), .FRAC_W(SFW)) dut_s (
        .clk(clk), .rst(rst), .mint_i(mint_s), .mfrac_i(mfrac_s),
        .int_mode_i(im_s), .adv_i(adv_s), .div_o(div_s)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic strobe_read(output int v);
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
        v = int'(div);
    endtask

    task automatic idle_read(output int v);
        adv = 1'b0;
        @(negedge clk);
        v = int'(div);
    endtask

    function automatic int rnd_mint();
        return 3 + int'($urandom_range(121));
    endfunction

    function automatic bit in_band(input int d);
        return (d >= -3) && (d <= 4);
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v, base, m0;
        int rec [12];
        longint sum, e;
        int seed_init;
        seed_init = int'($urandom(32'd20240611));

        rst = 1'b1; adv = 1'b0; im = 1'b0; mint = 7'd50; mfrac = '1;
        adv_s = 1'b0; im_s = 1'b0; mint_s = 7'd20; mfrac_s = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(div == 8'd50, "R1 reset output", div, 50);
        chk(div_s == 8'd20, "R1 reset output narrow", div_s, 20);

        // R7: all-ones fraction start-up corrections 0, +3, 0
        strobe_read(v); chk(v == 50, "R7 first", v, 50);
        strobe_read(v); chk(v == 53, "R7 second", v, 53);
        strobe_read(v); chk(v == 50, "R7 third", v, 50);

        // R3: no strobe, no change
        strobe_read(base);
        for (int i = 0; i < 4; i++) begin
            idle_read(v);
            chk(v == base, "R3 hold without strobe", v, base);
        end

        // R8: integer part change shows at once, state untouched
        mint = 7'd60;
        idle_read(v);
        chk(v == base + 10, "R8 mint step up", v, base + 10);
        mint = 7'd50;
        idle_read(v);
        chk(v == base, "R8 mint step back", v, base);

        // R4: integer-only mode is exact
        im = 1'b1;
        for (int i = 0; i < 8; i++) begin
            mint = 7'(rnd_mint());
            adv = 1'($urandom_range(1));
            @(negedge clk);
            v = int'(div);
            chk(v == int'(mint), "R4 integer-only exact", v, int'(mint));
        end
        adv = 1'b0;

        // R5: replay after leaving integer-only mode
        mfrac = 18'($urandom());
        mint = 7'd40;
        im = 1'b0;
        for (int i = 0; i < 12; i++) strobe_read(rec[i]);
        for (int i = 0; i < 30; i++) begin
            if ($urandom_range(1) == 1) idle_read(v);
            strobe_read(v);
            chk(in_band(v - 40), "R2 band during run", v - 40, 0);
        end
        im = 1'b1;
        idle_read(v);
        im = 1'b0;
        for (int i = 0; i < 12; i++) begin
            strobe_read(v);
            chk(v == rec[i], "R5 replay", v, rec[i]);
        end

        // R2: random controls, correction stays in band
        for (int b = 0; b < 6; b++) begin
            m0 = rnd_mint();
            mint = 7'(m0);
            mfrac = (b == 0) ? 18'd0 : 18'($urandom());
            for (int i = 0; i < 100; i++) begin
                if ($urandom_range(3) == 0) idle_read(v);
                strobe_read(v);
                chk(in_band(v - m0), "R2 correction band", v - m0, 0);
            end
        end

        // R6: long-run sum on the narrow instance
        for (int t = 0; t < 4; t++) begin
            int f, ms;
            f  = (t == 0) ? 0 : (t == 1) ? (1 << SFW) - 1 : int'($urandom_range((1 << SFW) - 1));
            ms = rnd_mint();
            mint_s  = 7'(ms);
            mfrac_s = SFW'(f);
            im_s = 1'b1;
            @(negedge clk);
            im_s = 1'b0;
            adv_s = 1'b1;
            sum = 0;
            for (int i = 0; i < SN; i++) begin
                @(negedge clk);
                sum += longint'(div_s);
            end
            adv_s = 1'b0;
            e = longint'(ms) * SN + longint'(SK) * (2 * f + 1);
            chk(sum >= e - 1 && sum <= e + 2, "R6 average over whole periods", sum, e);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule